// File: doc/BRIEF.md
# Saturating Fixed-Point Gain Stage

This block scales a stream of signed 16-bit samples by a programmable unsigned coefficient. The coefficient uses a Q2.14 scale, so 0x4000 is unity gain and 0xFFFF is just under four times. Host software converts a gain in decibels into this coefficient as round(16384 * 10^(dB/20)). For example, 0x0082 gives about -42 dB and 0x0084 gives about -41.9 dB.

Each strobed input sample is multiplied by the coefficient. The full product is rounded half-up and scaled down by 2^14. The result is clamped to the signed 16-bit range and registered, so the output strobe follows the input strobe one cycle later. A result that needs clamping raises a one-cycle saturation pulse together with the output strobe. The same pulse sets a sticky saturation flag, which holds until the host clears it.

Top module: `sat_gain_stage`

## Requirements
- R1: For an input x and coefficient c, when the result is in range, the output equals floor((x*c + 8192) / 16384), which is round-half-up of x*c/2^14.
- R2: A coefficient of 0x4000 gives an output equal to the input sample.
- R3: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high.
- R4: A result above 32767 gives an output of 32767 and `sat_pulse` high with the strobe.
- R5: A result below -32768 gives an output of -32768 and `sat_pulse` high with the strobe.
- R6: `sat_pulse` is high only together with `out_valid`, and only when R4 or R5 applies.
- R7: `sat_sticky` rises with `sat_pulse` and stays high until `sat_clr` is sampled high. If a clamp and `sat_clr` happen in the same cycle, the flag stays set.
- R8: A coefficient of 0 gives an output of 0 and no saturation.
- R9: `out_sample` keeps its value in cycles that follow a cycle with `in_valid` low.
- R10: After reset, `out_valid`, `out_sample`, `sat_pulse` and `sat_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| coef | input | 16 | Unsigned Q2.14 gain coefficient |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed scaled and clamped sample |
| sat_pulse | output | 1 | High with `out_valid` when the result was clamped |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The datapath keeps no state beyond its output register, so an error shows up at the port on the very next strobe. A wrong rounding offset or shift amount changes values near the half-LSB points; signed results of -1.5 and 0.5 expose it. A faulty clamp shows as a wrapped output or a missing pulse at the range edges. A flaw in the sticky flag shows as a flag that is lost, or never set, in the cycle after a clamp or a clear.

// File: rtl/sat_gain_stage.sv
module sat_gain_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [COEF_W-1:0] coef,
  input  logic              sat_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample,
  output logic              sat_pulse,
  output logic              sat_sticky
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int SHR_W  = PROD_W - FRAC_W;
  localparam logic signed [SHR_W-1:0] MAX_V = SHR_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [SHR_W-1:0] MIN_V = -SHR_W'(1 << (DATA_W-1));

  logic signed [PROD_W-1:0] prod, rnd;
  logic signed [SHR_W-1:0]  scaled;
  logic                     hi, lo;
  logic [DATA_W-1:0]        clamped;

  assign prod    = PROD_W'($signed(in_sample)) * $signed({1'b0, coef});
  assign rnd     = prod + PROD_W'(1 << (FRAC_W-1));
  assign scaled  = SHR_W'(rnd >>> FRAC_W);
  assign hi      = scaled > MAX_V;
  assign lo      = scaled < MIN_V;
  assign clamped = hi ? MAX_V[DATA_W-1:0] : lo ? MIN_V[DATA_W-1:0] : scaled[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      sat_pulse  <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      sat_pulse <= in_valid && (hi || lo);
      if (in_valid) out_sample <= clamped;
      if (in_valid && (hi || lo)) sat_sticky <= 1'b1;
      else if (sat_clr)           sat_sticky <= 1'b0;
    end
  end
endmodule

module sat_gain_stage_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_sample,
  input logic [COEF_W-1:0] coef,
  input logic              sat_clr,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sample,
  input logic              sat_pulse,
  input logic              sat_sticky
);
  localparam logic [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] BOT = {1'b1, {(DATA_W-1){1'b0}}};

  assert_strobe_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_strobe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_unity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && coef == COEF_W'(16'h4000) |=> out_sample == $past(in_sample) && !sat_pulse);
  assert_pulse_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pulse |-> out_valid);
  assert_pulse_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pulse |-> (out_sample == TOP || out_sample == BOT));
  assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pulse |-> sat_sticky);
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clr |=> sat_sticky);
  assert_zero_coef_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && coef == '0 |=> out_sample == '0 && !sat_pulse);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));
endmodule

bind sat_gain_stage sat_gain_stage_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample), .coef(coef),
  .sat_clr(sat_clr), .out_valid(out_valid), .out_sample(out_sample),
  .sat_pulse(sat_pulse), .sat_sticky(sat_sticky)
);

// File: tb/sat_gain_stage_tb.sv
module sat_gain_stage_tb;
  logic        clk = 0, rst_n = 0, in_valid = 0, sat_clr = 0;
  logic [15:0] in_sample = '0, coef = '0;
  logic        out_valid, sat_pulse, sat_sticky;
  logic [15:0] out_sample;
  int checks = 0, errors = 0;
  logic [16:0] exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  sat_gain_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample), .coef(coef),
    .sat_clr(sat_clr), .out_valid(out_valid), .out_sample(out_sample),
    .sat_pulse(sat_pulse), .sat_sticky(sat_sticky)
  );

  function automatic logic [16:0] model(input logic [15:0] x, input logic [15:0] c);
    longint r;
    r = (longint'($signed(x)) * longint'(c) + 8192) >>> 14;
    if (r > 32767)  return {1'b1, 16'h7FFF};
    if (r < -32768) return {1'b1, 16'h8000};
    return {1'b0, 16'(r)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] x, input logic [15:0] c);
    @(negedge clk);
    in_valid = 1; in_sample = x; coef = c;
    exp_q.push_back(model(x, c));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; sat_clr = 0;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected strobe", 1, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check("R1/R4/R5 sample", 32'(out_sample), 32'(e[15:0]));
        check("R6 sat_pulse", 32'(sat_pulse), 32'(e[16]));
      end
    end else check("R6 pulse without strobe", 32'(sat_pulse), 0);
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R10 out_valid", 32'(out_valid), 0);
    check("R10 out_sample", 32'(out_sample), 0);
    check("R10 sat_pulse", 32'(sat_pulse), 0);
    check("R10 sat_sticky", 32'(sat_sticky), 0);
    rst_n = 1;
    // R2 unity, back-to-back
    drive(16'h1234, 16'h4000); drive(16'h8000, 16'h4000); drive(16'h7FFF, 16'h4000);
    idle(2);
    // R1 rounding points and small gains
    drive(16'h0001, 16'h2000); drive(16'hFFFF, 16'h2000); drive(16'hFFFD, 16'h2000);
    drive(16'h7FFF, 16'h0082); drive(16'h8000, 16'h0084); drive(16'h0D05, 16'h1234);
    idle(2);
    check("R7 no sticky yet", 32'(sat_sticky), 0);
    // R8 zero coefficient
    drive(16'h7FFF, 16'h0000); drive(16'h8000, 16'h0000);
    idle(2);
    // R9 hold
    held = out_sample;
    idle(3);
    check("R9 hold", 32'(out_sample), 32'(held));
    check("R3 no strobe idle", 32'(out_valid), 0);
    // R4 / R5 clamps
    drive(16'h7FFF, 16'hFFFF); drive(16'h8000, 16'h4001); drive(16'h4000, 16'h8000);
    idle(1);
    check("R7 sticky set", 32'(sat_sticky), 1);
    idle(3);
    check("R7 sticky holds", 32'(sat_sticky), 1);
    @(negedge clk); sat_clr = 1;
    idle(1);
    check("R7 sticky cleared", 32'(sat_sticky), 0);
    // clamp and clear together: set wins
    drive(16'h8000, 16'hFFFF); sat_clr = 1;
    idle(1);
    check("R7 set wins", 32'(sat_sticky), 1);
    // sweep
    for (int i = 0; i < 200; i++) drive(16'(i * 16'd331 + 16'd7), 16'(i * 16'd977));
    idle(3);
    check("R3 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule